// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Engine

This block is a serial peripheral interface master. It takes words from a transmit queue, shifts them out most significant bit first on `mosi`, and at the same time shifts `miso` into a receive queue. Each queue holds 16 bytes. That is 16 entries for 8-bit words, 8 entries for 16-bit words and 4 entries for 32-bit words. The serial clock comes from the system clock through a 9-bit divisor. Idle clock level, launch edge and sample point are each set by their own control input.

The host loads words with `tx_push` and collects results with `rx_pop`, which reads the entry shown on `rx_data`. While the transmit queue has data, the engine runs word after word with no gap on the serial clock. It can optionally drive an active-low slave select for as long as transmit data is pending or a word is still shifting. Two sticky flags report a receive word lost because the queue was full and a pop made while the queue was empty. Deasserting `ctl_en` parks the clock, empties both queues and clears the flags.

Top module: `spim_engine`

## Requirements
- R1: Each serial clock half-period lasts `ctl_div`+1 system clock cycles, so the full period is 2×(`ctl_div`+1) cycles.
- R2: A word starts only while `ctl_en` and `ctl_master` are both 1. While `ctl_master` is 0, pushed words stay queued and `busy` stays 0.
- R3: Whenever no word is shifting, `sclk` equals `ctl_cpol`. A value of 1 gives an idle-high clock.
- R4: With `ctl_txedge`=1, `mosi` changes on active-to-idle clock edges and is stable at idle-to-active edges. With `ctl_txedge`=0 it is the other way round. Bits go out MSB first.
- R5: With `ctl_late_smp`=0, `miso` is captured at the end of the first half of each bit. With `ctl_late_smp`=1 it is captured at the end of the bit. The received word shows the first captured bit as its MSB.
- R6: `ctl_wsize` encodes 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 = 8 bits. Queue capacity is 16, 8 and 4 entries respectively. A push into a full transmit queue is ignored. Received words are zero-extended on `rx_data`.
- R7: When `ctl_hw_ss`=1 and the engine is enabled, `ss_n` is 0 while the transmit queue is non-empty or a word is shifting, and 1 otherwise. When `ctl_hw_ss`=0, `ss_n` stays 1.
- R8: A word that completes while the receive queue is full is discarded. The queue contents are kept, and `rx_overflow` sets and stays set while enabled.
- R9: A pop while the receive queue is empty leaves the level unchanged and sets `rx_underrun`, which stays set while enabled.
- R10: While the transmit queue holds data, the next word starts with no break in the serial clock cadence, and `ss_n` does not rise between words.
- R11: With `ctl_en`=0, both queues empty at the next edge, pushes are ignored, shifting stops with `sclk` at idle, and both flags clear.
- R12: After reset, levels are 0, `busy` and both flags are 0, `ss_n` is 1 and `sclk` is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Engine enable; 0 flushes and parks |
| ctl_master | input | 1 | Allows words to start |
| ctl_cpol | input | 1 | Idle level of sclk |
| ctl_txedge | input | 1 | 1: data launched on active-to-idle edge |
| ctl_late_smp | input | 1 | 1: sample miso at end of bit |
| ctl_wsize | input | 2 | Word size code |
| ctl_hw_ss | input | 1 | Hardware slave select enable |
| ctl_div | input | DIV_W | Clock divisor |
| tx_push | input | 1 | Push strobe for tx_data |
| tx_data | input | 32 | Word to transmit (low bits used) |
| rx_pop | input | 1 | Pop strobe for receive queue |
| rx_data | output | 32 | Head of receive queue |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| tx_level | output | LVL_W | Transmit queue entries |
| rx_level | output | LVL_W | Receive queue entries |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_overflow | output | 1 | Sticky lost-word flag |
| rx_underrun | output | 1 | Sticky empty-pop flag |
| busy | output | 1 | A word is shifting |

## Verification
The bench loops `mosi` back to `miso` in every word size and in both clock polarities and launch edges. A swapped edge or an LSB-first shifter then shows up as a wrong word on the independent bus monitor or in the receive queue. To separate the two sample points, `miso` is driven from the clock's active phase. A design that samples at the wrong point returns all ones where all zeros are expected, or the reverse. Capacity limits in each word size, overflow with a full receive queue (a faulty design overwrites the head or grows the level), gaps between back-to-back words, slave select release timing, and a mid-word disable that must leave nothing queued are each tested directly.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int WORD_MAX = 32;

    typedef enum logic [1:0] {
        WS_8   = 2'd0,
        WS_16  = 2'd1,
        WS_32  = 2'd2,
        WS_ALT = 2'd3
    } wsize_e;

    typedef struct packed {
        logic       busy;
        logic       half;
        logic [4:0] bitn;
    } shf_state_t;

    function automatic logic [5:0] word_bits(input wsize_e ws);
        case (ws)
            WS_16:   return 6'd16;
            WS_32:   return 6'd32;
            default: return 6'd8;
        endcase
    endfunction

    function automatic int fifo_cap(input wsize_e ws, input int bytes);
        return bytes / (int'(word_bits(ws)) / 8);
    endfunction

    function automatic logic [WORD_MAX-1:0] word_mask(input wsize_e ws);
        case (ws)
            WS_16:   return 32'h0000_FFFF;
            WS_32:   return 32'hFFFF_FFFF;
            default: return 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [LVL_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              push_ok, pop_ok;

    assign full    = (level >= cap);
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                can_start,
    input  logic                tick,
    input  wsize_e              wsize,
    input  logic                cpol,
    input  logic                txedge,
    input  logic                late_smp,
    input  logic                miso,
    input  logic [WORD_MAX-1:0] tx_word,
    output logic                tx_pop,
    output logic                rx_push,
    output logic [WORD_MAX-1:0] rx_word,
    output logic                busy,
    output logic                sclk,
    output logic                mosi
);
    shf_state_t          st;
    logic [WORD_MAX-1:0] txsh, rxsh, rx_next;
    logic [5:0]          nbits, shamt;
    logic                last_bit, sample_now, word_done, load;

    always_comb begin
        nbits      = word_bits(wsize);
        shamt      = 6'd32 - nbits;
        last_bit   = (st.bitn == 5'(nbits - 6'd1));
        sample_now = st.busy && tick && (st.half ? late_smp : !late_smp);
        rx_next    = sample_now ? {rxsh[WORD_MAX-2:0], miso} : rxsh;
        word_done  = st.busy && tick && st.half && last_bit;
        load       = en && can_start && (!st.busy || word_done);
    end

    assign tx_pop  = load;
    assign rx_push = word_done;
    assign rx_word = rx_next & word_mask(wsize);
    assign busy    = st.busy;
    assign sclk    = cpol ^ (st.busy && (st.half == txedge));
    assign mosi    = st.busy && txsh[WORD_MAX-1];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= '0;
            txsh <= '0;
            rxsh <= '0;
        end else if (load) begin
            st.busy <= 1'b1;
            st.half <= 1'b0;
            st.bitn <= '0;
            txsh    <= tx_word << shamt;
            rxsh    <= '0;
        end else if (word_done) begin
            st.busy <= 1'b0;
        end else if (st.busy && tick) begin
            st.half <= ~st.half;
            rxsh    <= rx_next;
            if (st.half) begin
                st.bitn <= st.bitn + 1'b1;
                txsh    <= {txsh[WORD_MAX-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int  FIFO_BYTES = 16,
    parameter int  DIV_W      = 9,
    localparam int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_en,
    input  logic                ctl_master,
    input  logic                ctl_cpol,
    input  logic                ctl_txedge,
    input  logic                ctl_late_smp,
    input  logic [1:0]          ctl_wsize,
    input  logic                ctl_hw_ss,
    input  logic [DIV_W-1:0]    ctl_div,
    input  logic                tx_push,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                rx_pop,
    output logic [WORD_MAX-1:0] rx_data,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                ss_n,
    output logic [LVL_W-1:0]    tx_level,
    output logic [LVL_W-1:0]    rx_level,
    output logic                tx_full,
    output logic                rx_empty,
    output logic                rx_overflow,
    output logic                rx_underrun,
    output logic                busy
);
    wsize_e              ws;
    logic [LVL_W-1:0]    cap;
    logic                tx_empty, rx_full;
    logic                tx_pop, rx_push, tick;
    logic [WORD_MAX-1:0] tx_head, rx_word;

    assign ws  = wsize_e'(ctl_wsize);
    assign cap = LVL_W'(fifo_cap(ws, FIFO_BYTES));

    spim_fifo #(.DEPTH(FIFO_BYTES), .DATA_W(WORD_MAX), .LVL_W(LVL_W)) u_txq (
        .clk(clk), .rst(rst), .flush(!ctl_en), .cap(cap),
        .push(tx_push), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.DEPTH(FIFO_BYTES), .DATA_W(WORD_MAX), .LVL_W(LVL_W)) u_rxq (
        .clk(clk), .rst(rst), .flush(!ctl_en), .cap(cap),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_data), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(busy), .div(ctl_div), .tick(tick)
    );

    spim_shift u_shift (
        .clk(clk), .rst(rst), .en(ctl_en),
        .can_start(ctl_master && !tx_empty), .tick(tick),
        .wsize(ws), .cpol(ctl_cpol), .txedge(ctl_txedge),
        .late_smp(ctl_late_smp), .miso(miso), .tx_word(tx_head),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .busy(busy), .sclk(sclk), .mosi(mosi)
    );

    assign ss_n = !(ctl_hw_ss && ctl_en && (busy || !tx_empty));

    always_ff @(posedge clk) begin
        if (rst || !ctl_en) begin
            rx_overflow <= 1'b0;
            rx_underrun <= 1'b0;
        end else begin
            if (rx_push && rx_full) rx_overflow <= 1'b1;
            if (rx_pop && rx_empty) rx_underrun <= 1'b1;
        end
    end

endmodule

// File: rtl/spim_engine_chk.sv
module spim_engine_chk
    import spim_pkg::*;
#(
    parameter int  FIFO_BYTES = 16,
    parameter int  DIV_W      = 9,
    localparam int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_en,
    input logic             ctl_cpol,
    input logic [1:0]       ctl_wsize,
    input logic             ctl_hw_ss,
    input logic             sclk,
    input logic             ss_n,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_overflow,
    input logic             rx_underrun
);
    logic [LVL_W-1:0] cap_c;
    assign cap_c = LVL_W'(fifo_cap(wsize_e'(ctl_wsize), FIFO_BYTES));

    // R3
    idle_clock_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> (sclk == ctl_cpol));

    // R11
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> (tx_level == '0 && rx_level == '0));

    // R6
    capacity_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_en |=> (tx_level <= cap_c && rx_level <= cap_c));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_overflow && ctl_en) |=> rx_overflow);

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_underrun && ctl_en) |=> rx_underrun);

    // R7
    ss_soft_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_hw_ss |-> ss_n);

    // R7
    ss_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_hw_ss && ctl_en && tx_level != '0) |-> !ss_n);

endmodule

bind spim_engine spim_engine_chk #(.FIFO_BYTES(FIFO_BYTES), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/spim_engine_test.sv
`timescale 1ns/1ps
module spim_engine_test;
    localparam int LVL_W = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_en = 1'b0, ctl_master = 1'b0, ctl_cpol = 1'b0;
    logic        ctl_txedge = 1'b1, ctl_late_smp = 1'b0, ctl_hw_ss = 1'b0;
    logic [1:0]  ctl_wsize = 2'd0;
    logic [8:0]  ctl_div = 9'd0;
    logic        tx_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] tx_data = '0;
    logic [31:0] rx_data;
    logic        miso, sclk, mosi, ss_n;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic        tx_full, rx_empty, rx_overflow, rx_underrun, busy;
    logic        loop_mode = 1'b1;

    int nvec = 0, nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign miso = loop_mode ? mosi : (sclk ^ ctl_cpol);

    spim_engine uut (.*);

    // bus monitor
    int          cyc = 0, last_tog = 0, gap_err = 0, ss_rise = 0;
    bit          have_last = 0;
    logic        sclk_prev = 1'b0, ss_prev = 1'b1;
    logic [31:0] mon_sh = '0;
    int          mon_bits = 0, cap_n = 0, cur_bits = 8;
    logic [31:0] cap_q [16];

    always @(negedge clk) begin
        if (sclk !== sclk_prev) begin
            if (have_last && (cyc - last_tog) != int'(ctl_div) + 1) gap_err++;
            last_tog  = cyc;
            have_last = 1;
            if (ctl_txedge ? (sclk != ctl_cpol) : (sclk == ctl_cpol)) begin
                mon_sh = {mon_sh[30:0], mosi};
                mon_bits++;
                if (mon_bits == cur_bits) begin
                    if (cap_n < 16) cap_q[cap_n] = mon_sh & ((cur_bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << cur_bits) - 1));
                    cap_n++;
                    mon_bits = 0;
                end
            end
        end
        if (ss_n === 1'b1 && ss_prev === 1'b0) ss_rise++;
        sclk_prev = sclk;
        ss_prev   = ss_n;
        cyc++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    function automatic logic [31:0] msk(input int bits);
        return (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 1);
    endfunction

    task automatic configure(input logic [1:0] ws, input logic cpol, input logic txe,
                             input logic smp, input logic [8:0] dv, input logic hss);
        @(negedge clk);
        ctl_en = 0; ctl_master = 0;
        @(negedge clk);
        ctl_wsize = ws; ctl_cpol = cpol; ctl_txedge = txe; ctl_late_smp = smp;
        ctl_div = dv; ctl_hw_ss = hss;
        cur_bits = (ws == 2'd1) ? 16 : (ws == 2'd2) ? 32 : 8;
        @(negedge clk);
        sclk_prev = sclk; mon_bits = 0; cap_n = 0; gap_err = 0; have_last = 0; ss_rise = 0;
        ctl_en = 1;
        @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        tx_data = w; tx_push = 1;
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic pop_chk(input string req, input logic [31:0] exp);
        chk(req, rx_data, exp);
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic wait_idle;
        int n = 0;
        while ((busy || tx_level != 0) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) chk("R2 idle timeout", 32'd1, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R12 sclk", {31'd0, sclk}, 32'd0);
        chk("R12 ss_n", {31'd0, ss_n}, 32'd1);
        chk("R12 levels", {tx_level, rx_level}, 32'd0);
        chk("R12 flags", {busy, rx_overflow, rx_underrun}, 32'd0);
    endtask

    task automatic t_loop(input string tag, input logic [1:0] ws, input logic cpol,
                          input logic txe, input logic smp, input logic [8:0] dv,
                          input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        logic [31:0] w [3];
        w[0] = w0; w[1] = w1; w[2] = w2;
        loop_mode = 1;
        configure(ws, cpol, txe, smp, dv, 1'b0);
        for (int i = 0; i < 3; i++) push(w[i]);
        chk({tag, " R2 held"}, {31'd0, busy}, 32'd0);
        have_last = 0;
        ctl_master = 1;
        wait_idle();
        // R1 R10: uniform half-periods, no gap across words
        chk({tag, " R1 R10 cadence"}, gap_err, 0);
        chk({tag, " R3 idle"}, {31'd0, sclk}, {31'd0, cpol});
        chk({tag, " R4 words seen"}, cap_n, 3);
        for (int i = 0; i < 3; i++) chk({tag, " R4 mosi word"}, cap_q[i], w[i] & msk(cur_bits));
        chk({tag, " R6 rx level"}, {27'd0, rx_level}, 32'd3);
        for (int i = 0; i < 3; i++) pop_chk({tag, " R5 R6 rx word"}, w[i] & msk(cur_bits));
    endtask

    task automatic t_sample_point;
        loop_mode = 0;
        configure(2'd0, 1'b0, 1'b1, 1'b0, 9'd2, 1'b0);
        ctl_master = 1;
        push(32'h5A);
        wait_idle();
        pop_chk("R5 mid sample", 32'h00);
        configure(2'd0, 1'b0, 1'b1, 1'b1, 9'd2, 1'b0);
        ctl_master = 1;
        push(32'h5A);
        wait_idle();
        pop_chk("R5 end sample", 32'hFF);
        loop_mode = 1;
    endtask

    task automatic t_capacity;
        configure(2'd2, 1'b0, 1'b1, 1'b0, 9'd0, 1'b0);
        for (int i = 0; i < 6; i++) push(32'h1000_0000 + i);
        chk("R6 cap32", {27'd0, tx_level}, 32'd4);
        chk("R6 full32", {31'd0, tx_full}, 32'd1);
        chk("R2 no start", {31'd0, busy}, 32'd0);
        ctl_master = 1;
        wait_idle();
        chk("R6 rx32", {27'd0, rx_level}, 32'd4);
        pop_chk("R6 first kept", 32'h1000_0000);
        configure(2'd1, 1'b0, 1'b1, 1'b0, 9'd0, 1'b0);
        for (int i = 0; i < 10; i++) push(32'h55 + i);
        chk("R6 cap16", {27'd0, tx_level}, 32'd8);
        configure(2'd3, 1'b0, 1'b1, 1'b0, 9'd0, 1'b0);
        for (int i = 0; i < 17; i++) push(32'h7 + i);
        chk("R6 cap8", {27'd0, tx_level}, 32'd16);
    endtask

    task automatic t_overflow;
        configure(2'd2, 1'b1, 1'b0, 1'b0, 9'd0, 1'b0);
        for (int i = 0; i < 4; i++) push(32'hC0DE_0000 + i);
        ctl_master = 1;
        wait_idle();
        chk("R8 no ovf yet", {31'd0, rx_overflow}, 32'd0);
        push(32'hDEAD_BEEF);
        wait_idle();
        chk("R8 ovf set", {31'd0, rx_overflow}, 32'd1);
        chk("R8 level kept", {27'd0, rx_level}, 32'd4);
        pop_chk("R8 head kept", 32'hC0DE_0000);
        chk("R8 sticky", {31'd0, rx_overflow}, 32'd1);
        for (int i = 1; i < 4; i++) pop_chk("R8 rest kept", 32'hC0DE_0000 + i);
        chk("R9 no udf yet", {31'd0, rx_underrun}, 32'd0);
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
        @(negedge clk);
        chk("R9 udf set", {31'd0, rx_underrun}, 32'd1);
        chk("R9 level", {27'd0, rx_level}, 32'd0);
    endtask

    task automatic t_ss;
        configure(2'd0, 1'b0, 1'b1, 1'b0, 9'd1, 1'b0);
        ctl_master = 1;
        push(32'h3C);
        repeat (3) @(negedge clk);
        chk("R7 soft ss", {31'd0, ss_n}, 32'd1);
        wait_idle();
        configure(2'd0, 1'b0, 1'b1, 1'b0, 9'd1, 1'b1);
        chk("R7 idle high", {31'd0, ss_n}, 32'd1);
        for (int i = 0; i < 3; i++) push(32'h81 + i);
        chk("R7 pending low", {31'd0, ss_n}, 32'd0);
        ctl_master = 1;
        wait_idle();
        chk("R10 one release", ss_rise, 1);
        chk("R7 released", {31'd0, ss_n}, 32'd1);
    endtask

    task automatic t_disable;
        configure(2'd1, 1'b1, 1'b1, 1'b0, 9'd3, 1'b0);
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
        ctl_master = 1;
        for (int i = 0; i < 3; i++) push(32'hAB00 + i);
        repeat (40) @(negedge clk);
        ctl_en = 0;
        @(negedge clk);
        chk("R11 levels", {tx_level, rx_level}, 32'd0);
        chk("R11 stopped", {31'd0, busy}, 32'd0);
        chk("R11 sclk idle", {31'd0, sclk}, 32'd1);
        chk("R11 flags", {rx_overflow, rx_underrun}, 32'd0);
        push(32'h1234);
        chk("R11 push ignored", {27'd0, tx_level}, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        t_reset();
        t_loop("m0 w8",  2'd0, 1'b0, 1'b1, 1'b0, 9'd3, 32'hA5, 32'h3C, 32'h81);
        t_loop("m3 w16", 2'd1, 1'b1, 1'b0, 1'b0, 9'd0, 32'hBEEF, 32'h0001, 32'h8000);
        t_loop("m1 w32", 2'd2, 1'b0, 1'b0, 1'b1, 9'd5, 32'hA5C3_96E1, 32'h0000_0001, 32'h8000_0000);
        t_loop("m2 w8",  2'd0, 1'b1, 1'b1, 1'b1, 9'd1, 32'h1F, 32'hF0, 32'h66);
        t_sample_point();
        t_capacity();
        t_overflow();
        t_ss();
        t_disable();
        report();
    end

endmodule